// File: doc/BRIEF.md
# 8x8 Bit Matrix Transpose Unit

This execution unit views a 64-bit source operand as a square grid of eight rows by eight columns of bits and returns the grid reflected about its main diagonal. The path contains no arithmetic; it only moves bits. A single registered stage sits behind the permutation, so the result, a valid flag and the condition field all appear one clock after the operand is accepted.

When the record flag comes with a valid operand, the unit also writes a 4-bit condition field. This field says whether the transposed result is negative, positive or zero as a signed 64-bit value, and it carries a copy of the incoming summary-overflow bit. If the record flag is clear, the condition field keeps its previous value. Instruction decode, register-file access and writeback arbitration belong to the surrounding pipeline.

Top module: `bmt_transpose_unit`

## Requirements
- R1: While reset is high and in the first cycle after it falls, out_valid is 0, out_result is all zeros and out_cond is 4'b0000.
- R2: out_valid is 1 in the cycle after a cycle with in_valid high, and 0 in the cycle after a cycle with in_valid low.
- R3: Bits are numbered MSB-first, so bit index i is vector position 63-i. For every row j and column k in 0..7, result bit index j*8+k equals source bit index k*8+j.
- R4: The eight diagonal bits (j equal to k) reach the result in their original positions. Passing a result through the unit a second time gives back the original operand.
- R5: When in_valid is low, out_result keeps its previous value.
- R6: An accepted operand with in_record=1 loads out_cond with {LT,GT,EQ,SO} at positions [3],[2],[1],[0]. LT is result bit index 0 (vector bit 63). EQ is 1 when the result is zero. GT is 1 when neither LT nor EQ is set. SO is in_so.
- R7: An accepted operand with in_record=0 leaves out_cond unchanged.
- R8: out_cond[3:1] never has more than one bit set. After a recorded update exactly one of them is set.
- R9: in_record and in_so have no effect when in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_operand | input | 64 | Source bit matrix, MSB-first rows |
| in_record | input | 1 | Update the condition field |
| in_so | input | 1 | Current summary-overflow bit |
| out_valid | output | 1 | Result register holds a new value |
| out_result | output | 64 | Transposed matrix |
| out_cond | output | 4 | Condition field {LT,GT,EQ,SO} |

## Verification
Every result of the unit is due exactly one clock edge after its operand is sampled: out_valid, out_result and, when the record flag is set, out_cond. The bench changes inputs on the falling edge and holds them for one full cycle. It then compares all three outputs on the next falling edge, which comes half a cycle after the capturing rising edge. It checks the following falling edge again to confirm that out_valid has dropped and that the result and condition field are held. The transpose is compared against a reference computed in the bench with MSB-first indices, and the involution property is checked by sending each result back through the unit.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
    localparam int MAT_DIM  = 8;
    localparam int MAT_BITS = MAT_DIM * MAT_DIM;

    // Condition field layout, MSB first: negative, positive, zero, overflow copy
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    localparam cond_t COND_CLEAR = '{lt: 1'b0, gt: 1'b0, eq: 1'b0, so: 1'b0};
endpackage

// File: rtl/bmt_permute.sv
// Pure wiring: reflects a DIM x DIM bit grid about its main diagonal.
// With MSB-first numbering, index j*DIM+k sits at vector position
// W-1-(j*DIM+k) = (DIM-1-j)*DIM + (DIM-1-k). The reflection therefore has the
// same form in LSB-first positions, so it is written that way here.
module bmt_permute #(
    parameter  int DIM = 8,
    localparam int W   = DIM * DIM
) (
    input  logic [W-1:0] src,
    output logic [W-1:0] dst
);
    for (genvar r = 0; r < DIM; r++) begin : g_row
        for (genvar c = 0; c < DIM; c++) begin : g_col
            assign dst[r*DIM + c] = src[c*DIM + r];
        end
    end
endmodule

// File: rtl/bmt_cond_eval.sv
// Classifies a result as a signed value and attaches the overflow copy.
module bmt_cond_eval
    import bmt_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] value,
    input  logic         so_in,
    output cond_t        cond
);
    logic is_zero;
    logic is_neg;

    always_comb begin
        is_zero = (value == '0);
        is_neg  = value[W-1];
        cond.lt = is_neg;
        cond.eq = is_zero;
        cond.gt = !is_neg && !is_zero;
        cond.so = so_in;
    end
endmodule

// File: rtl/bmt_transpose_unit.sv
module bmt_transpose_unit
    import bmt_pkg::*;
#(
    parameter  int DIM = MAT_DIM,
    localparam int W   = DIM * DIM
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_operand,
    input  logic         in_record,
    input  logic         in_so,
    output logic         out_valid,
    output logic [W-1:0] out_result,
    output logic [3:0]   out_cond
);
    logic [W-1:0] perm_w;
    cond_t        cond_next;
    cond_t        cond_q;
    logic         valid_q;
    logic [W-1:0] result_q;

    bmt_permute #(.DIM(DIM)) u_perm (
        .src (in_operand),
        .dst (perm_w)
    );

    bmt_cond_eval #(.W(W)) u_cond (
        .value (perm_w),
        .so_in (in_so),
        .cond  (cond_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            result_q <= '0;
            cond_q   <= COND_CLEAR;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                result_q <= perm_w;
                if (in_record) begin
                    cond_q <= cond_next;
                end
            end
        end
    end

    assign out_valid  = valid_q;
    assign out_result = result_q;
    assign out_cond   = cond_q;
endmodule

// File: rtl/bmt_transpose_chk.sv
module bmt_transpose_chk #(
    parameter  int DIM = 8,
    localparam int W   = DIM * DIM
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] in_operand,
    input logic         in_record,
    input logic         in_so,
    input logic         out_valid,
    input logic [W-1:0] out_result,
    input logic [3:0]   out_cond
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R4
    diag_top_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_result[W-1] == $past(in_operand[W-1]));
    // R3
    first_row_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_result[W-2] == $past(in_operand[W-1-DIM]));
    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));
    // R6
    so_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_record) |=> out_cond[0] == $past(in_so));
    // R6
    lt_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_record) |=> out_cond[3] == out_result[W-1]);
    // R7
    cond_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_record) |=> $stable(out_cond));
    // R9
    idle_cond_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_cond));
    // R8
    class_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_cond[3:1]));
    // R8
    class_set_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_record) |=> $countones(out_cond[3:1]) == 1);
endmodule

bind bmt_transpose_unit bmt_transpose_chk #(.DIM(DIM)) chk_i (.*);

// File: tb/bmt_transpose_unit_tb_top.sv
module bmt_transpose_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic        in_record = 1'b0;
    logic        in_so = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic [3:0]  out_cond;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;   // 50 MHz

    bmt_transpose_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
        .in_record(in_record), .in_so(in_so), .out_valid(out_valid),
        .out_result(out_result), .out_cond(out_cond)
    );

    // Reference with MSB-first indices: index i lives at vector position 63-i
    function automatic logic [63:0] ref_transpose(input logic [63:0] s);
        logic [63:0] r = '0;
        for (int j = 0; j < 8; j++)
            for (int k = 0; k < 8; k++)
                r[63 - (j*8 + k)] = s[63 - (k*8 + j)];
        return r;
    endfunction

    function automatic logic [3:0] ref_cond(input logic [63:0] r, input logic so);
        logic lt = r[63];
        logic eq = (r == 64'd0);
        return {lt, !lt && !eq, eq, so};
    endfunction

    function automatic logic [63:0] next_rand();
        logic [63:0] x = rng;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        rng = x;
        return x;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one operand for one cycle; outputs are checked on the falling edge
    // half a cycle after the rising edge that captured it.
    task automatic apply(input logic [63:0] op, input logic rec, input logic so);
        @(negedge clk);
        in_valid = 1'b1; in_operand = op; in_record = rec; in_so = so;
        @(negedge clk);
        in_valid = 1'b0; in_record = 1'b0; in_so = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 valid", {63'd0, out_valid}, 64'd0);
        check("R1 result", out_result, 64'd0);
        check("R1 cond", {60'd0, out_cond}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after release", {63'd0, out_valid}, 64'd0);
        check("R1 cond after release", {60'd0, out_cond}, 64'd0);
    endtask

    task automatic t_single_bits();
        for (int i = 0; i < 64; i += 9) begin
            logic [63:0] op = 64'd1 << i;
            apply(op, 1'b0, 1'b0);
            check("R3 single bit", out_result, ref_transpose(op));
        end
        apply(64'h0040_0000_0000_0000, 1'b0, 1'b0);   // index 9: row 1 col 1
        check("R4 diagonal bit", out_result, 64'h0040_0000_0000_0000);
        apply(64'h4000_0000_0000_0000, 1'b0, 1'b0);   // index 1 -> index 8
        check("R3 off-diagonal bit", out_result, 64'h0080_0000_0000_0000);
    endtask

    task automatic t_latency();
        apply(64'hFF00_0000_0000_0000, 1'b0, 1'b0);
        check("R2 valid after input", {63'd0, out_valid}, 64'd1);
        check("R3 top row to left column", out_result, 64'h8080_8080_8080_8080);
        @(negedge clk);
        check("R2 valid drops", {63'd0, out_valid}, 64'd0);
        check("R5 result held", out_result, 64'h8080_8080_8080_8080);
    endtask

    task automatic t_cond_classes();
        apply(64'd0, 1'b1, 1'b1);
        check("R6 zero result", {60'd0, out_cond}, 64'h3);          // EQ, SO
        apply(64'h8000_0000_0000_0000, 1'b1, 1'b0);
        check("R6 negative result", {60'd0, out_cond}, 64'h8);      // LT
        apply(64'h0000_0000_0000_0100, 1'b1, 1'b0);
        check("R6 positive result", {60'd0, out_cond}, 64'h4);      // GT
        apply(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1);
        check("R3 all ones", out_result, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R8 all ones class", {60'd0, out_cond}, 64'h9);
    endtask

    task automatic t_record_hold();
        apply(64'h0123_4567_89AB_CDEF, 1'b1, 1'b1);
        check("R6 recorded", {60'd0, out_cond},
              {60'd0, ref_cond(ref_transpose(64'h0123_4567_89AB_CDEF), 1'b1)});
        apply(64'd0, 1'b0, 1'b0);
        check("R7 cond unchanged", {60'd0, out_cond},
              {60'd0, ref_cond(ref_transpose(64'h0123_4567_89AB_CDEF), 1'b1)});
        check("R7 result still updates", out_result, 64'd0);
    endtask

    task automatic t_idle_ignored();
        logic [3:0]  c0;
        logic [63:0] r0;
        apply(64'h8000_0000_0000_0001, 1'b1, 1'b0);
        c0 = out_cond; r0 = out_result;
        @(negedge clk);
        in_valid = 1'b0; in_record = 1'b1; in_so = 1'b1; in_operand = 64'd0;
        @(negedge clk);
        in_record = 1'b0; in_so = 1'b0;
        check("R9 cond untouched", {60'd0, out_cond}, {60'd0, c0});
        check("R9 result untouched", out_result, r0);
        check("R9 valid low", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_random_involution();
        for (int n = 0; n < 40; n++) begin
            logic [63:0] op = next_rand();
            logic [63:0] once;
            logic        so = op[5];
            apply(op, 1'b1, so);
            once = out_result;
            check("R3 random", once, ref_transpose(op));
            check("R6 random cond", {60'd0, out_cond}, {60'd0, ref_cond(ref_transpose(op), so)});
            apply(once, 1'b0, 1'b0);
            check("R4 twice restores", out_result, op);
        end
    endtask

    initial begin
        t_reset();
        t_single_bits();
        t_latency();
        t_cond_classes();
        t_record_hold();
        t_idle_ignored();
        t_random_involution();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule